// File: doc/BRIEF.md
# Three-Channel Prioritised Link Packet Framer

The framer collects 32-bit application words from three virtual channels (trigger, data transfer, and slow control/monitoring) and turns them into 80-bit link packets. Each packet is a 16-bit header above a 64-bit payload. Two words from one channel fill a payload. A word marked as the channel's last, arriving when no partner word is buffered, goes out alone with the upper half of the payload zeroed. The header names the destination and the local source node, the word count, a content kind (data or a control kind such as a network header or a termination word), the originating channel, and a 4-bit checksum. The checksum is chosen so that the XOR of all twenty nibbles of the packet is zero.

When more than one channel holds a complete packet, a trigger packet is always sent first. Data and slow-control packets take turns. Each channel works stop-and-wait. Once its packet has been sent, the channel keeps it and accepts no new words until the far end returns an ack pulse for that channel. A nack pulse puts the same packet back in line, so it is resent before that channel can accept anything new. An accepted output packet stays unchanged on the link side until the link takes it.

Top module: `vcf_framer`

## Requirements
- R1: Packet bit layout: pktData[79:77] destination, [76:74] source (myAddr), [73:72] word count, [71:70] kind, [69:68] channel id, [67:64] checksum, [63:32] second word, [31:0] first word. The word count is only ever 1 or 2.
- R2: Two words accepted on one channel form one packet with word count 2. A word with chLast high accepted into an empty channel forms a packet with word count 1 and [63:32] equal to zero.
- R3: The kind field carries the chKind value sampled with the packet's first word. The codes are 00 data, 01 network header, 10 termination and 11 spare.
- R4: The channel id field is 0 for trigger, 1 for data and 2 for slow control. It never reads 3.
- R5: The checksum field makes the XOR of all twenty 4-bit nibbles of pktData equal to zero.
- R6: When the trigger channel and any other channel hold complete packets together, the trigger packet is presented first.
- R7: When only data and slow control compete, the one not served most recently goes first. After reset, data is favoured.
- R8: While pktValid is high and pktReady is low, pktValid stays high and pktData holds its value.
- R9: chReady for a channel drops once that channel holds a complete packet. It stays low after the packet is sent, and returns high only after an ack pulse for that channel.
- R10: A nack pulse for a channel whose packet was sent makes the identical packet appear again, and the channel stays not-ready meanwhile.
- R11: After reset, pktValid is low and all three chReady bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| myAddr | input | 3 | Local node address placed in the source field |
| chValid | input | 3 | Word valid per channel (bit 0 trigger, 1 data, 2 slow control) |
| chLast | input | 3 | Marks a channel's word as the last one of its message |
| chKind | input | 6 | Content kind per channel, 2 bits each, sampled with the first word |
| chDst | input | 9 | Destination address per channel, 3 bits each, sampled with the first word |
| chWord | input | 96 | Application word per channel, 32 bits each |
| chReady | output | 3 | Channel can accept a word this cycle |
| pktValid | output | 1 | A link packet is presented |
| pktData | output | 80 | Presented link packet |
| pktReady | input | 1 | Link takes the presented packet |
| ackPulse | input | 3 | Per-channel acknowledge of the sent packet |
| nackPulse | input | 3 | Per-channel report of a corrupted packet |

## Verification
The assertions watch the link side on every cycle. They check that a held packet stays stable under backpressure, that each presented packet has a zero nibble XOR, that the word count lies in range, that a single-word packet has a zero upper half, and that the channel id is legal. Ordering across channels is left to the bench's scenarios, since it depends on which channels filled together and on earlier grants. These cover trigger precedence over the others, alternation between data and slow control, the ready gating around ack, and the replay of an identical packet after a nack.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
  localparam int NCH    = 3;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int LEN_W  = 2;
  localparam int KIND_W = 2;
  localparam int CHID_W = 2;
  localparam int SUM_W  = 4;
  localparam int HDR_W  = 2 * ADDR_W + LEN_W + KIND_W + CHID_W + SUM_W;
  localparam int PAY_W  = 2 * WORD_W;
  localparam int PKT_W  = HDR_W + PAY_W;
  localparam int NIB    = PKT_W / SUM_W;

  localparam int CH_TRIG = 0;
  localparam int CH_DATA = 1;
  localparam int CH_SLOW = 2;

  typedef enum logic [1:0] {
    SLOT_EMPTY,
    SLOT_HALF,
    SLOT_FULL,
    SLOT_SENT
  } slotState_t;

  typedef struct packed {
    logic [NCH-1:0]    loadLo;
    logic [NCH-1:0]    loadHi;
    logic              loadOut;
    logic [CHID_W-1:0] outSel;
  } strobes_t;

  function automatic logic [SUM_W-1:0] nibFold(input logic [PKT_W-1:0] p);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NIB; k++) acc ^= p[k*SUM_W +: SUM_W];
    return acc;
  endfunction

  function automatic logic [PKT_W-1:0] buildPkt(
    input logic [ADDR_W-1:0] dst,
    input logic [ADDR_W-1:0] src,
    input logic [LEN_W-1:0]  len,
    input logic [KIND_W-1:0] kind,
    input logic [CHID_W-1:0] chId,
    input logic [WORD_W-1:0] hi,
    input logic [WORD_W-1:0] lo
  );
    logic [PKT_W-1:0] p;
    p = {dst, src, len, kind, chId, {SUM_W{1'b0}}, hi, lo};
    p[PAY_W +: SUM_W] = nibFold(p);
    return p;
  endfunction
endpackage

// File: rtl/vcf_ctrl.sv
module vcf_ctrl
  import vcf_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] chValid,
  input  logic [NCH-1:0] chLast,
  input  logic [NCH-1:0] ackPulse,
  input  logic [NCH-1:0] nackPulse,
  input  logic           pktReady,
  output logic [NCH-1:0] chReady,
  output logic           pktValid,
  output strobes_t       stb
);
  logic [NCH-1:0]    isEmpty;
  logic [NCH-1:0]    isHalf;
  logic [NCH-1:0]    isFull;
  logic              haveGrant;
  logic [CHID_W-1:0] gSel;
  logic              outFree;
  logic              take;
  logic              rrSlow;

  // fixed priority for trigger, alternation between data and slow control
  always_comb begin
    haveGrant = |isFull;
    gSel      = '0;
    if (isFull[CH_TRIG])                       gSel = CHID_W'(CH_TRIG);
    else if (isFull[CH_DATA] && isFull[CH_SLOW]) gSel = rrSlow ? CHID_W'(CH_SLOW) : CHID_W'(CH_DATA);
    else if (isFull[CH_DATA])                  gSel = CHID_W'(CH_DATA);
    else if (isFull[CH_SLOW])                  gSel = CHID_W'(CH_SLOW);
  end

  assign outFree    = !pktValid || pktReady;
  assign take       = outFree && haveGrant;
  assign stb.loadOut = take;
  assign stb.outSel  = gSel;

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    slotState_t st;

    assign isEmpty[i]    = (st == SLOT_EMPTY);
    assign isHalf[i]     = (st == SLOT_HALF);
    assign isFull[i]     = (st == SLOT_FULL);
    assign chReady[i]    = isEmpty[i] || isHalf[i];
    assign stb.loadLo[i] = chValid[i] && isEmpty[i];
    assign stb.loadHi[i] = chValid[i] && isHalf[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st <= SLOT_EMPTY;
      end else begin
        unique case (st)
          SLOT_EMPTY: if (chValid[i]) st <= chLast[i] ? SLOT_FULL : SLOT_HALF;
          SLOT_HALF:  if (chValid[i]) st <= SLOT_FULL;
          SLOT_FULL:  if (take && gSel == CHID_W'(i)) st <= SLOT_SENT;
          SLOT_SENT: begin
            if (ackPulse[i])       st <= SLOT_EMPTY;
            else if (nackPulse[i]) st <= SLOT_FULL;
          end
          default: st <= SLOT_EMPTY;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktValid <= 1'b0;
      rrSlow   <= 1'b0;
    end else begin
      if (outFree) pktValid <= haveGrant;
      if (take) begin
        if (gSel == CHID_W'(CH_DATA))      rrSlow <= 1'b1;
        else if (gSel == CHID_W'(CH_SLOW)) rrSlow <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vcf_dpath.sv
module vcf_dpath
  import vcf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       myAddr,
  input  logic [NCH*KIND_W-1:0]   chKind,
  input  logic [NCH*ADDR_W-1:0]   chDst,
  input  logic [NCH*WORD_W-1:0]   chWord,
  input  strobes_t                stb,
  output logic [PKT_W-1:0]        pktData
);
  logic [PKT_W-1:0] cand [NCH];
  logic [PKT_W-1:0] selPkt;

  for (genvar i = 0; i < NCH; i++) begin : g_buf
    logic [WORD_W-1:0] lo;
    logic [WORD_W-1:0] hi;
    logic [LEN_W-1:0]  len;
    logic [KIND_W-1:0] kind;
    logic [ADDR_W-1:0] dst;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lo   <= '0;
        hi   <= '0;
        len  <= '0;
        kind <= '0;
        dst  <= '0;
      end else if (stb.loadLo[i]) begin
        lo   <= chWord[i*WORD_W +: WORD_W];
        hi   <= '0;
        len  <= LEN_W'(1);
        kind <= chKind[i*KIND_W +: KIND_W];
        dst  <= chDst[i*ADDR_W +: ADDR_W];
      end else if (stb.loadHi[i]) begin
        hi  <= chWord[i*WORD_W +: WORD_W];
        len <= LEN_W'(2);
      end
    end

    assign cand[i] = buildPkt(dst, myAddr, len, kind, CHID_W'(i), hi, lo);
  end

  always_comb begin
    selPkt = '0;
    for (int i = 0; i < NCH; i++)
      if (stb.outSel == CHID_W'(i)) selPkt = cand[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pktData <= '0;
    else if (stb.loadOut) pktData <= selPkt;
  end
endmodule

// File: rtl/vcf_framer.sv
module vcf_framer
  import vcf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     myAddr,
  input  logic [NCH-1:0]        chValid,
  input  logic [NCH-1:0]        chLast,
  input  logic [NCH*KIND_W-1:0] chKind,
  input  logic [NCH*ADDR_W-1:0] chDst,
  input  logic [NCH*WORD_W-1:0] chWord,
  output logic [NCH-1:0]        chReady,
  output logic                  pktValid,
  output logic [PKT_W-1:0]      pktData,
  input  logic                  pktReady,
  input  logic [NCH-1:0]        ackPulse,
  input  logic [NCH-1:0]        nackPulse
);
  strobes_t stb;

  vcf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chLast(chLast),
    .ackPulse(ackPulse), .nackPulse(nackPulse), .pktReady(pktReady),
    .chReady(chReady), .pktValid(pktValid), .stb(stb)
  );

  vcf_dpath u_dpath (
    .clk(clk), .rstN(rstN), .myAddr(myAddr), .chKind(chKind),
    .chDst(chDst), .chWord(chWord), .stb(stb), .pktData(pktData)
  );
endmodule

// File: rtl/vcf_framer_chk.sv
module vcf_framer_chk
  import vcf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             pktValid,
  input logic             pktReady,
  input logic [PKT_W-1:0] pktData
);
  logic [SUM_W-1:0] fold;
  always_comb begin
    fold = '0;
    for (int k = 0; k < NIB; k++) fold ^= pktData[k*SUM_W +: SUM_W];
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && !pktReady |=> pktValid && $stable(pktData));

  // R5
  nibble_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> fold == '0);

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (pktData[73:72] == 2'd1 || pktData[73:72] == 2'd2));

  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && pktData[73:72] == 2'd1 |-> pktData[63:32] == '0);

  // R4
  chan_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> pktData[69:68] != 2'd3);
endmodule

bind vcf_framer vcf_framer_chk u_chk (
  .clk(clk), .rstN(rstN), .pktValid(pktValid),
  .pktReady(pktReady), .pktData(pktData)
);

// File: tb/vcf_framer_test.sv
module vcf_framer_test;
  localparam logic [2:0] SRC = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  myAddr = SRC;
  logic [2:0]  chValid = '0;
  logic [2:0]  chLast = '0;
  logic [5:0]  chKind = '0;
  logic [8:0]  chDst = '0;
  logic [95:0] chWord = '0;
  logic [2:0]  chReady;
  logic        pktValid;
  logic [79:0] pktData;
  logic        pktReady = 1'b0;
  logic [2:0]  ackPulse = '0;
  logic [2:0]  nackPulse = '0;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  vcf_framer uut (
    .clk(clk), .rstN(rstN), .myAddr(myAddr), .chValid(chValid), .chLast(chLast),
    .chKind(chKind), .chDst(chDst), .chWord(chWord), .chReady(chReady),
    .pktValid(pktValid), .pktData(pktData), .pktReady(pktReady),
    .ackPulse(ackPulse), .nackPulse(nackPulse)
  );

  function automatic logic [3:0] foldAll(input logic [79:0] p);
    logic [3:0] s = '0;
    for (int k = 0; k < 20; k++) s ^= p[k*4 +: 4];
    return s;
  endfunction

  function automatic logic [79:0] mk(input logic [2:0] dst, input logic [1:0] len,
                                     input logic [1:0] kind, input logic [1:0] ch,
                                     input logic [31:0] hi, input logic [31:0] lo);
    logic [79:0] p;
    p = {dst, SRC, len, kind, ch, 4'h0, hi, lo};
    p[67:64] = foldAll(p);
    return p;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setCh(input int ch, input logic [31:0] w, input logic last,
                       input logic [1:0] kind, input logic [2:0] dst);
    chValid[ch] = 1'b1;
    chLast[ch] = last;
    chWord[ch*32 +: 32] = w;
    chKind[ch*2 +: 2] = kind;
    chDst[ch*3 +: 3] = dst;
  endtask

  task automatic endPush();
    @(negedge clk);
    chValid = '0;
    chLast = '0;
  endtask

  task automatic expectPkt(input string req, input logic [79:0] exp);
    int n = 0;
    while (!pktValid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check({req, " valid"}, 80'(pktValid), 80'(1));
    check(req, pktData, exp);
  endtask

  task automatic acceptPkt();
    @(negedge clk); pktReady = 1'b1;
    @(negedge clk); pktReady = 1'b0;
  endtask

  task automatic ackCh(input int ch);
    @(negedge clk); ackPulse[ch] = 1'b1;
    @(negedge clk); ackPulse = '0;
  endtask

  task automatic nackCh(input int ch);
    @(negedge clk); nackPulse[ch] = 1'b1;
    @(negedge clk); nackPulse = '0;
  endtask

  task automatic t_reset();
    // R11
    check("R11 pktValid", 80'(pktValid), 80'(0));
    check("R11 chReady", 80'(chReady), 80'(3'b111));
  endtask

  task automatic t_basic();
    logic [79:0] exp = mk(3'd6, 2'd2, 2'b00, 2'd1, 32'hBBBB_0002, 32'hAAAA_0001);
    @(negedge clk); setCh(1, 32'hAAAA_0001, 1'b0, 2'b00, 3'd6);
    @(negedge clk); chValid[1] = 1'b1; chWord[63:32] = 32'hBBBB_0002; chLast[1] = 1'b1;
    endPush();
    expectPkt("R1 R2 R4 two-word data packet", exp);
    check("R5 nibble fold", 80'(foldAll(pktData)), 80'(0));
    check("R9 not ready while held", 80'(chReady[1]), 80'(0));
    repeat (3) @(negedge clk);
    check("R8 held under backpressure", pktData, exp);
    check("R8 valid kept", 80'(pktValid), 80'(1));
    acceptPkt();
    check("R8 released", 80'(pktValid), 80'(0));
    check("R9 not ready before ack", 80'(chReady[1]), 80'(0));
    ackCh(1);
    check("R9 ready after ack", 80'(chReady[1]), 80'(1));
  endtask

  task automatic t_single();
    @(negedge clk); setCh(2, 32'hC0DE_1234, 1'b1, 2'b10, 3'd1);
    endPush();
    expectPkt("R2 R3 single padded termination", mk(3'd1, 2'd1, 2'b10, 2'd2, 32'h0, 32'hC0DE_1234));
    check("R5 nibble fold single", 80'(foldAll(pktData)), 80'(0));
    acceptPkt();
    ackCh(2);
  endtask

  task automatic t_prio();
    @(negedge clk);
    setCh(0, 32'h7000_0000, 1'b0, 2'b01, 3'd2);
    setCh(1, 32'h7100_0000, 1'b0, 2'b00, 3'd3);
    setCh(2, 32'h7200_0000, 1'b0, 2'b00, 3'd4);
    @(negedge clk);
    setCh(0, 32'h7000_0001, 1'b1, 2'b01, 3'd2);
    setCh(1, 32'h7100_0001, 1'b1, 2'b00, 3'd3);
    setCh(2, 32'h7200_0001, 1'b1, 2'b00, 3'd4);
    endPush();
    expectPkt("R6 R3 trigger network header first",
              mk(3'd2, 2'd2, 2'b01, 2'd0, 32'h7000_0001, 32'h7000_0000));
    acceptPkt();
    expectPkt("R7 data favoured after reset-order",
              mk(3'd3, 2'd2, 2'b00, 2'd1, 32'h7100_0001, 32'h7100_0000));
    acceptPkt();
    expectPkt("R7 slow control next",
              mk(3'd4, 2'd2, 2'b00, 2'd2, 32'h7200_0001, 32'h7200_0000));
    acceptPkt();
    ackCh(0); ackCh(1); ackCh(2);
    check("R9 all ready after acks", 80'(chReady), 80'(3'b111));
  endtask

  task automatic t_rr();
    @(negedge clk); setCh(1, 32'h8100_0000, 1'b1, 2'b00, 3'd0);
    endPush();
    expectPkt("R7 lone data packet", mk(3'd0, 2'd1, 2'b00, 2'd1, 32'h0, 32'h8100_0000));
    acceptPkt();
    ackCh(1);
    @(negedge clk);
    setCh(1, 32'h8100_0001, 1'b1, 2'b00, 3'd0);
    setCh(2, 32'h8200_0001, 1'b1, 2'b00, 3'd7);
    endPush();
    expectPkt("R7 slow wins after data served",
              mk(3'd7, 2'd1, 2'b00, 2'd2, 32'h0, 32'h8200_0001));
    acceptPkt();
    expectPkt("R7 data follows", mk(3'd0, 2'd1, 2'b00, 2'd1, 32'h0, 32'h8100_0001));
    acceptPkt();
    ackCh(1); ackCh(2);
  endtask

  task automatic t_nack();
    logic [79:0] exp = mk(3'd3, 2'd2, 2'b00, 2'd0, 32'h9000_0002, 32'h9000_0001);
    @(negedge clk); setCh(0, 32'h9000_0001, 1'b0, 2'b00, 3'd3);
    @(negedge clk); setCh(0, 32'h9000_0002, 1'b1, 2'b00, 3'd3);
    endPush();
    expectPkt("R10 first send", exp);
    acceptPkt();
    check("R10 nothing presented before nack", 80'(pktValid), 80'(0));
    nackCh(0);
    check("R10 not ready during resend", 80'(chReady[0]), 80'(0));
    expectPkt("R10 identical resend", exp);
    acceptPkt();
    ackCh(0);
    check("R9 ready after final ack", 80'(chReady[0]), 80'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_single();
    t_prio();
    t_rr();
    t_nack();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule